// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block sits on the read path of a NOR-style flash device. While an internal program or erase operation is running, it replaces the read data byte with progress status. The top bit reports completion polarity. Bit 6 flips on every finished read cycle while an operation is active. Bit 2 flips only on reads that address a sector chosen for erasure. When no operation is active, the array data passes through untouched.

The command decoder, the cell array and the program and erase algorithms sit outside this block. They reach it as input flags: busy and suspend state, bit 7 of the datum being written, whether the read address lies in a sector chosen for erasure, and whether the target of the latest command is protected. A single-cycle `cmd_start` pulse marks the rising edge of the last write strobe of a command sequence. That pulse starts a new status session. If the target is protected, it also opens a fixed busy window, counted in clock cycles, after which the block returns to array reads on its own. An erase that hits only some protected sectors is reported by the outside logic through the ordinary erase-busy flag.

Top module: `flash_status_gen`

## Requirements
- R1: While `prog_busy` or `susp_prog` is 1, bit 7 of `rd_data` is the inverse of `prog_bit7`. Once both clear and no other status source is active, `rd_data` shows the array byte, which carries the true programmed value.
- R2: While `erase_busy` is 1, bit 7 reads 0. In erase suspend (`erase_susp`=1, no program active) a read with `addr_in_erase`=1 returns bit 7 = 1.
- R3: Bit 6 inverts after each completed read cycle while a program or erase is running, including program during erase suspend, whatever the read address.
- R4: During erase suspend with no program active, bit 6 keeps its value across read cycles.
- R5: Bit 2 inverts after a completed read only when `addr_in_erase` is 1 in an erase context (erase busy, erase window, or erase suspend). Reads with `addr_in_erase`=0 leave it unchanged.
- R6: A `cmd_start` pulse clears both toggle bits, so the first status read after a command shows bit 6 = 0 and bit 2 = 0.
- R7: A `cmd_start` with `prot_target`=1 and `cmd_is_erase`=0 shows program status (bit 7 = ~`prog_bit7`) for exactly PROG_WIN_US*CLK_PER_US cycles after the capturing edge, then array data.
- R8: A `cmd_start` with `prot_target`=1 and `cmd_is_erase`=1 shows erase status (bit 7 = 0) for exactly ERASE_WIN_US*CLK_PER_US cycles after the capturing edge, then array data.
- R9: When no operation flag is set and no window is running, `rd_data` equals `array_data`. This also holds during erase suspend for reads with `addr_in_erase`=0.
- R10: In any status mode, bits 5, 4, 3, 1 and 0 of `rd_data` read 0.
- R11: The toggle bits update only when `rd_strobe` falls. The value read stays constant while the strobe is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle pulse at the end of a program or erase command |
| cmd_is_erase | input | 1 | Command kind qualifier for `cmd_start`: 1 = erase, 0 = program |
| prot_target | input | 1 | Target of the command is protected (for erase: all selected sectors) |
| prog_busy | input | 1 | Program operation running |
| erase_busy | input | 1 | Erase operation running |
| erase_susp | input | 1 | Erase is suspended |
| susp_prog | input | 1 | Program running inside erase suspend |
| prog_bit7 | input | 1 | Bit 7 of the datum being programmed |
| addr_in_erase | input | 1 | Current read address lies in a sector chosen for erasure |
| rd_strobe | input | 1 | Read cycle strobe, high for the duration of a read |
| array_data | input | DATA_W | Data read from the cell array |
| rd_data | output | DATA_W | Read byte: status or array data |

## Verification
The assertions assume that the operation flags, `addr_in_erase` and `prog_bit7` stay stable while `rd_strobe` is high and across the edge where it falls. They also assume that `cmd_start` lasts a single cycle and that a protection window is not combined with live busy flags of the other kind. The bench drives every input on the falling clock edge and changes flags only between read cycles, with the strobe low. It issues a new command only after the previous session has ended. Under these conditions, each sampled value depends only on the count of completed reads since the last command.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_PROG  = 2'd1,
        MODE_ERASE = 2'd2,
        MODE_SUSP  = 2'd3
    } fsg_mode_e;

    typedef struct packed {
        logic tog6;
        logic tog2;
    } fsg_tog_s;

    localparam int unsigned BIT_POLL = 7;
    localparam int unsigned BIT_TOGA = 6;
    localparam int unsigned BIT_TOGB = 2;

endpackage

// File: rtl/fsg_rd_edge.sv
module fsg_rd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    output logic rd_done
);
    typedef struct packed {
        logic strobe;
    } edge_s;

    edge_s st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = rd_strobe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_done = st_q.strobe & ~rd_strobe;
endmodule

// File: rtl/fsg_prot_window.sv
module fsg_prot_window #(
    parameter int unsigned PROG_LEN  = 250,
    parameter int unsigned ERASE_LEN = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_is_erase,
    input  logic prot_target,
    output logic win_act,
    output logic win_erase
);
    localparam int unsigned MAX_LEN = (PROG_LEN > ERASE_LEN) ? PROG_LEN : ERASE_LEN;
    localparam int unsigned CW      = $clog2(MAX_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          is_erase;
    } win_s;

    win_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (cmd_start) begin
            st_d.is_erase = cmd_is_erase;
            if (prot_target) st_d.cnt = cmd_is_erase ? CW'(ERASE_LEN) : CW'(PROG_LEN);
            else             st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_act   = (st_q.cnt != '0);
    assign win_erase = st_q.is_erase;
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle
    import fsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_start,
    input  logic      rd_done,
    input  fsg_mode_e mode,
    input  logic      addr_in_erase,
    input  logic      erase_susp,
    output fsg_tog_s  tog
);
    fsg_tog_s st_d, st_q;
    logic     run_op;
    logic     erase_ctx;

    always_comb begin
        run_op    = (mode == MODE_PROG) || (mode == MODE_ERASE);
        erase_ctx = (mode == MODE_ERASE) || (mode == MODE_SUSP) ||
                    ((mode == MODE_PROG) && erase_susp);
        st_d = st_q;
        if (cmd_start) begin
            st_d = '0;
        end else if (rd_done) begin
            if (run_op)                     st_d.tog6 = ~st_q.tog6;
            if (erase_ctx && addr_in_erase) st_d.tog2 = ~st_q.tog2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tog = st_q;
endmodule

// File: rtl/fsg_compose.sv
module fsg_compose
    import fsg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  fsg_mode_e         mode,
    input  logic              prog_bit7,
    input  fsg_tog_s          tog,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    logic poll_bit;

    always_comb begin
        unique case (mode)
            MODE_PROG:  poll_bit = ~prog_bit7;
            MODE_ERASE: poll_bit = 1'b0;
            default:    poll_bit = 1'b1;
        endcase
        if (mode == MODE_ARRAY) begin
            rd_data = array_data;
        end else begin
            rd_data           = '0;
            rd_data[BIT_POLL] = poll_bit;
            rd_data[BIT_TOGA] = tog.tog6;
            rd_data[BIT_TOGB] = tog.tog2;
        end
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned CLK_PER_US   = 125,
    parameter int unsigned PROG_WIN_US  = 2,
    parameter int unsigned ERASE_WIN_US = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_is_erase,
    input  logic              prot_target,
    input  logic              prog_busy,
    input  logic              erase_busy,
    input  logic              erase_susp,
    input  logic              susp_prog,
    input  logic              prog_bit7,
    input  logic              addr_in_erase,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned PROG_LEN  = CLK_PER_US * PROG_WIN_US;
    localparam int unsigned ERASE_LEN = CLK_PER_US * ERASE_WIN_US;

    logic      rd_done;
    logic      win_act;
    logic      win_erase;
    fsg_mode_e mode;
    fsg_tog_s  tog;

    fsg_rd_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .rd_done   (rd_done)
    );

    fsg_prot_window #(
        .PROG_LEN  (PROG_LEN),
        .ERASE_LEN (ERASE_LEN)
    ) u_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_is_erase (cmd_is_erase),
        .prot_target  (prot_target),
        .win_act      (win_act),
        .win_erase    (win_erase)
    );

    always_comb begin
        if (prog_busy || susp_prog || (win_act && !win_erase))
            mode = MODE_PROG;
        else if (erase_busy || (win_act && win_erase))
            mode = MODE_ERASE;
        else if (erase_susp && addr_in_erase)
            mode = MODE_SUSP;
        else
            mode = MODE_ARRAY;
    end

    fsg_toggle u_tog (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_start     (cmd_start),
        .rd_done       (rd_done),
        .mode          (mode),
        .addr_in_erase (addr_in_erase),
        .erase_susp    (erase_susp),
        .tog           (tog)
    );

    fsg_compose #(.DATA_W(DATA_W)) u_out (
        .mode       (mode),
        .prog_bit7  (prog_bit7),
        .tog        (tog),
        .array_data (array_data),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              prog_busy,
    input logic              erase_busy,
    input logic              erase_susp,
    input logic              susp_prog,
    input logic              prog_bit7,
    input logic              addr_in_erase,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              win_act
);
    logic susp_only;
    assign susp_only = erase_susp && addr_in_erase && !prog_busy && !susp_prog &&
                       !erase_busy && !win_act;

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> (rd_data[7] == ~prog_bit7)); // R1

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && !prog_busy && !susp_prog && !win_act) |-> (rd_data[7] == 1'b0)); // R2

    AST_RUN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_strobe) && prog_busy && !cmd_start) |=>
        (!prog_busy || (rd_data[6] != $past(rd_data[6])))); // R3

    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_strobe) && susp_only && !cmd_start) |=>
        (!susp_only || (rd_data[6] == $past(rd_data[6])))); // R4

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_busy || erase_busy || susp_prog) |->
        (rd_data[5:3] == 3'b000 && rd_data[1:0] == 2'b00)); // R10

    AST_WIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(win_act) && !prog_busy && !erase_busy && !erase_susp && !susp_prog) |->
        (rd_data == array_data)); // R7
endmodule

bind flash_status_gen flash_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_start     (cmd_start),
    .prog_busy     (prog_busy),
    .erase_busy    (erase_busy),
    .erase_susp    (erase_susp),
    .susp_prog     (susp_prog),
    .prog_bit7     (prog_bit7),
    .addr_in_erase (addr_in_erase),
    .rd_strobe     (rd_strobe),
    .array_data    (array_data),
    .rd_data       (rd_data),
    .win_act       (win_act)
);

// File: tb/flash_status_gen_test.sv
`timescale 1ns/1ps
module flash_status_gen_test;
    localparam int unsigned CPU   = 125;
    localparam int unsigned PWUS  = 2;
    localparam int unsigned EWUS  = 100;
    localparam int unsigned PLEN  = CPU * PWUS;
    localparam int unsigned ELEN  = CPU * EWUS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 0, cmd_is_erase = 0, prot_target = 0;
    logic       prog_busy = 0, erase_busy = 0, erase_susp = 0, susp_prog = 0;
    logic       prog_bit7 = 0, addr_in_erase = 0, rd_strobe = 0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    flash_status_gen #(
        .DATA_W(8), .CLK_PER_US(CPU), .PROG_WIN_US(PWUS), .ERASE_WIN_US(EWUS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_is_erase(cmd_is_erase),
        .prot_target(prot_target), .prog_busy(prog_busy), .erase_busy(erase_busy),
        .erase_susp(erase_susp), .susp_prog(susp_prog), .prog_bit7(prog_bit7),
        .addr_in_erase(addr_in_erase), .rd_strobe(rd_strobe),
        .array_data(array_data), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic pulse_cmd(input logic erase, input logic prot);
        @(negedge clk);
        cmd_is_erase = erase; prot_target = prot; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; prot_target = 1'b0;
    endtask

    // one read cycle: value early in strobe, value late in strobe
    task automatic do_read(output logic [7:0] v1, output logic [7:0] v2);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); v1 = rd_data;
        @(negedge clk); v2 = rd_data; rd_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_idle;
        logic [7:0] a, b;
        array_data = 8'h3C;
        @(negedge clk);
        chk("R9 reset passthrough", rd_data, 8'h3C);
        do_read(a, b);
        chk("R9 idle read", a, 8'h3C);
        array_data = 8'hE1;
        do_read(a, b);
        chk("R9 idle read 2", a, 8'hE1);
    endtask

    task automatic t_program;
        logic [7:0] a, b;
        array_data = 8'h5A; prog_bit7 = 1'b1;
        pulse_cmd(1'b0, 1'b0);
        prog_busy = 1'b1;
        do_read(a, b);
        chk("R1 R6 R10 first program read", a, 8'h00);
        chk("R11 stable within read", b, a);
        do_read(a, b);
        chk("R3 program toggle", a, 8'h40);
        do_read(a, b);
        chk("R3 program toggle back", a, 8'h00);
        prog_bit7 = 1'b0;
        do_read(a, b);
        chk("R1 inverse of zero datum", a, 8'hC0);
        @(negedge clk); prog_busy = 1'b0; array_data = 8'h85;
        @(negedge clk);
        chk("R1 true datum after done", rd_data, 8'h85);
    endtask

    task automatic t_erase;
        logic [7:0] a, b;
        array_data = 8'hFF;
        pulse_cmd(1'b1, 1'b0);
        erase_busy = 1'b1; addr_in_erase = 1'b1;
        do_read(a, b);
        chk("R2 R6 erase first read", a, 8'h00);
        do_read(a, b);
        chk("R5 erase both toggle", a, 8'h44);
        do_read(a, b);
        chk("R5 erase both back", a, 8'h00);
        addr_in_erase = 1'b0;
        do_read(a, b);
        chk("R3 erase any address", a, 8'h44);
        do_read(a, b);
        chk("R5 bit2 holds outside sector", a, 8'h04);
        @(negedge clk); erase_busy = 1'b0; erase_susp = 1'b1; addr_in_erase = 1'b1;
        do_read(a, b);
        chk("R2 suspend poll high", a, 8'hC4);
        do_read(a, b);
        chk("R4 suspend bit6 holds", a, 8'hC0);
        @(negedge clk); addr_in_erase = 1'b0; array_data = 8'h27;
        do_read(a, b);
        chk("R9 suspend outside sector", a, 8'h27);
        prog_bit7 = 1'b0;
        pulse_cmd(1'b0, 1'b0);
        susp_prog = 1'b1;
        do_read(a, b);
        chk("R1 R6 suspend-program first", a, 8'h80);
        do_read(a, b);
        chk("R3 suspend-program toggles", a, 8'hC0);
        @(negedge clk); susp_prog = 1'b0; erase_susp = 1'b0;
        @(negedge clk);
        chk("R9 back to array", rd_data, 8'h27);
    endtask

    task automatic t_prot_prog;
        array_data = 8'hA5; prog_bit7 = 1'b1;
        pulse_cmd(1'b0, 1'b1);
        chk("R7 window opens", rd_data, 8'h00);
        repeat (PLEN - 1) @(negedge clk);
        chk("R7 window last cycle", rd_data, 8'h00);
        @(negedge clk);
        chk("R7 window closed", rd_data, 8'hA5);
    endtask

    task automatic t_prot_erase;
        array_data = 8'hFF;
        pulse_cmd(1'b1, 1'b1);
        chk("R8 window opens", rd_data, 8'h00);
        repeat (ELEN - 1) @(negedge clk);
        chk("R8 window last cycle", rd_data, 8'h00);
        @(negedge clk);
        chk("R8 window closed", rd_data, 8'hFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_program();
        t_erase();
        t_prot_prog();
        t_prot_erase();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule